// File: doc/BRIEF.md
# Hit FIFO Input Pipeline

This block moves hit words out of an external first-in first-out memory and turns them into addresses for a lookup RAM. A small read controller turns downstream pop requests into single-word reads. It drives an active-low read enable toward the FIFO and never reads while the FIFO reports empty. A pop that cannot be served at once is counted as pending and served later. Each word read is captured in a holding register. A one-cycle data-valid flag then moves the word's low address bits into the output address register, with no further handshake.

A host path sits in front of the output register. While host mode is selected, hit reads are suspended and the output register loads a host-supplied address on each host write strobe. Pop requests that arrive in host mode are kept pending and are served once host mode is released.

Top module: `hit_fifo_ingress`

## Requirements
- R1: During and straight after reset, `fifo_ren_no` is 1, `hold_valid_o` is 0 and `addr_o` is 0.
- R2: `fifo_ren_no` is 0 only in cycles where `fifo_empty_ni` is 1 (the FIFO holds data, active-low empty flag deasserted).
- R3: A pop request (`pop_i`=1) in a cycle where the FIFO holds data, no pop is pending and host mode is off drives `fifo_ren_no` low in that same cycle. Each read cycle takes exactly one word.
- R4: Pops that cannot be served are counted, up to 2^CNT_W-1. Each counted pop produces one read, issued in the first cycles in which the FIFO holds data and host mode is off.
- R5: `hold_valid_o` is 1 in exactly the cycles that follow a cycle with `fifo_ren_no` low.
- R6: Outside host mode, `addr_o` takes bits [ADDR_W-1:0] of the word read, at the clock edge that ends the cycle in which `hold_valid_o` is 1. Bits above ADDR_W-1 are discarded, and words leave in FIFO order.
- R7: `addr_o` keeps its value in every cycle with neither a hit load nor a host write.
- R8: While `host_mode_i` is 1, `fifo_ren_no` stays 1 even if pops arrive and the FIFO holds data.
- R9: With `host_mode_i` and `host_wr_i` both 1, `addr_o` takes `host_data_i` at the next clock edge.
- R10: While `host_mode_i` is 1, a pending `hold_valid_o` has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_ni | input | 1 | FIFO empty flag, active low (1 = data present) |
| fifo_data_i | input | HIT_W | Word at the FIFO head |
| fifo_ren_no | output | 1 | FIFO read enable, active low |
| pop_i | input | 1 | Downstream request for one hit word |
| host_mode_i | input | 1 | Host owns the address register |
| host_wr_i | input | 1 | Host write strobe |
| host_data_i | input | ADDR_W | Host address word |
| hold_valid_o | output | 1 | Holding register was loaded at the last edge |
| addr_o | output | ADDR_W | Lookup RAM address |

## Verification
The checks assume the FIFO behaves like a first-word-fall-through memory. They assume the head word is valid whenever `fifo_empty_ni` is 1, and that the word is consumed at the edge that ends a cycle with `fifo_ren_no` low. The bench models the FIFO exactly that way, so it never presents data while it reports empty. The checks on the host path take host strobes to be meaningful only while host mode is selected. The stimulus therefore raises `host_wr_i` only inside host windows. It also avoids issuing a host write in the cycle where a dropped hit would otherwise land.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int unsigned HIT_W_DEF  = 23;
  localparam int unsigned ADDR_W_DEF = 17;
  localparam int unsigned CNT_W_DEF  = 4;

  typedef enum logic [1:0] {
    SEL_KEEP = 2'd0,
    SEL_HIT  = 2'd1,
    SEL_HOST = 2'd2
  } addr_sel_e;
endpackage

// File: rtl/hfp_rd_ctrl.sv
module hfp_rd_ctrl #(
  parameter int unsigned CNT_W = hfp_pkg::CNT_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pop_i,
  input  logic fifo_empty_ni,
  input  logic host_mode_i,
  output logic fifo_ren_no,
  output logic rd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pend_q, pend_d;
  logic             want, ready;

  assign want  = pop_i || (pend_q != '0);
  assign ready = fifo_empty_ni && !host_mode_i;
  assign rd_o  = want && ready;
  assign fifo_ren_no = !rd_o;

  // pending counter: +1 per pop, -1 per read, saturating
  always_comb begin
    pend_d = pend_q;
    if (pop_i && !rd_o) begin
      if (pend_q != CNT_MAX) pend_d = pend_q + 1'b1;
    end else if (!pop_i && rd_o) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  AST_NO_READ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_empty_ni |-> fifo_ren_no); // R2
  AST_HOST_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i |-> fifo_ren_no); // R8
  AST_PEND_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && !pop_i && ready) |=> (pend_q == $past(pend_q) - 1'b1)); // R4
endmodule

// File: rtl/hfp_hold_stage.sv
module hfp_hold_stage #(
  parameter int unsigned HIT_W = hfp_pkg::HIT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [HIT_W-1:0] d_i,
  output logic [HIT_W-1:0] q_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ld_i;
      if (ld_i) q_o <= d_i;
    end
  end

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> valid_o); // R5
  AST_VALID_ONLY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> !valid_o); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/hfp_addr_stage.sv
module hfp_addr_stage #(
  parameter int unsigned HIT_W  = hfp_pkg::HIT_W_DEF,
  parameter int unsigned ADDR_W = hfp_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIT_W-1:0]  hit_i,
  input  logic              hit_vld_i,
  input  logic              host_mode_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_data_i,
  output logic [ADDR_W-1:0] addr_o
);
  import hfp_pkg::*;

  addr_sel_e         sel;
  logic [ADDR_W-1:0] hit_addr;

  assign hit_addr = hit_i[ADDR_W-1:0];

  always_comb begin
    sel = SEL_KEEP;
    if (host_mode_i) begin
      if (host_wr_i) sel = SEL_HOST;
    end else if (hit_vld_i) begin
      sel = SEL_HIT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else begin
      unique case (sel)
        SEL_HIT:  addr_o <= hit_addr;
        SEL_HOST: addr_o <= host_data_i;
        default:  addr_o <= addr_o;
      endcase
    end
  end

  AST_HIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_vld_i && !host_mode_i) |=> addr_o == $past(hit_i[ADDR_W-1:0])); // R6
  AST_HOST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && host_wr_i) |=> addr_o == $past(host_data_i)); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_vld_i && !(host_mode_i && host_wr_i)) |=> $stable(addr_o)); // R7
  AST_HOST_BLOCKS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !host_wr_i) |=> $stable(addr_o)); // R10
endmodule

// File: rtl/hit_fifo_ingress.sv
module hit_fifo_ingress #(
  parameter int unsigned HIT_W  = hfp_pkg::HIT_W_DEF,
  parameter int unsigned ADDR_W = hfp_pkg::ADDR_W_DEF,
  parameter int unsigned CNT_W  = hfp_pkg::CNT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_ni,
  input  logic [HIT_W-1:0]  fifo_data_i,
  output logic              fifo_ren_no,
  input  logic              pop_i,
  input  logic              host_mode_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_data_i,
  output logic              hold_valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             rd;
  logic [HIT_W-1:0] hold_q;

  hfp_rd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pop_i        (pop_i),
    .fifo_empty_ni(fifo_empty_ni),
    .host_mode_i  (host_mode_i),
    .fifo_ren_no  (fifo_ren_no),
    .rd_o         (rd)
  );

  hfp_hold_stage #(.HIT_W(HIT_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (rd),
    .d_i    (fifo_data_i),
    .q_o    (hold_q),
    .valid_o(hold_valid_o)
  );

  hfp_addr_stage #(.HIT_W(HIT_W), .ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hold_q),
    .hit_vld_i  (hold_valid_o),
    .host_mode_i(host_mode_i),
    .host_wr_i  (host_wr_i),
    .host_data_i(host_data_i),
    .addr_o     (addr_o)
  );

  AST_READ_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_ren_no |=> hold_valid_o); // R5
  AST_READ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_ren_no |-> fifo_empty_ni && !host_mode_i); // R2
endmodule

// File: tb/sim_hit_fifo_ingress.sv
module sim_hit_fifo_ingress;
  localparam int HIT_W  = 23;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fifo_empty_ni = 1'b0;
  logic [HIT_W-1:0]  fifo_data_i = '0;
  logic              fifo_ren_no;
  logic              pop_i = 1'b0;
  logic              host_mode_i = 1'b0;
  logic              host_wr_i = 1'b0;
  logic [ADDR_W-1:0] host_data_i = '0;
  logic              hold_valid_o;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0;
  int n_err = 0;
  logic [HIT_W-1:0]  fq[$];
  logic [ADDR_W-1:0] exp_q[$];
  logic prev_rd = 1'b0;
  int   rd_total = 0;
  logic mon_on = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  hit_fifo_ingress u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_empty_ni(fifo_empty_ni),
    .fifo_data_i(fifo_data_i), .fifo_ren_no(fifo_ren_no), .pop_i(pop_i),
    .host_mode_i(host_mode_i), .host_wr_i(host_wr_i), .host_data_i(host_data_i),
    .hold_valid_o(hold_valid_o), .addr_o(addr_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: settle the previous read, drive new inputs, check read enable
  task automatic tick(input bit pop, input bit host, input bit wr, input logic [ADDR_W-1:0] hd);
    @(negedge clk);
    chk(hold_valid_o == prev_rd, "R5", hold_valid_o, prev_rd);
    if (prev_rd) begin
      exp_q.push_back(fq[0][ADDR_W-1:0]);
      void'(fq.pop_front());
      rd_total++;
    end
    pop_i = pop; host_mode_i = host; host_wr_i = wr; host_data_i = hd;
    fifo_empty_ni = (fq.size() != 0);
    fifo_data_i   = (fq.size() != 0) ? fq[0] : '0;
    #1;
    if (!fifo_empty_ni) chk(fifo_ren_no == 1'b1, "R2", fifo_ren_no, 1);
    if (host) chk(fifo_ren_no == 1'b1, "R8", fifo_ren_no, 1);
    prev_rd = !fifo_ren_no;
  endtask

  // scoreboard monitor on the address register
  initial begin
    logic              hv_l = 1'b0, host_l = 1'b0, wr_l = 1'b0;
    logic [ADDR_W-1:0] hd_l = '0, addr_l = '0, e;
    forever begin
      @(negedge clk);
      #2;
      if (mon_on) begin
        if (hv_l) begin
          e = exp_q.pop_front();
          if (!host_l) chk(addr_o == e, "R6", addr_o, e);
          else if (!wr_l) chk(addr_o == addr_l, "R10", addr_o, addr_l);
        end
        if (host_l && wr_l) chk(addr_o == hd_l, "R9", addr_o, hd_l);
        else if (!hv_l) chk(addr_o == addr_l, "R7", addr_o, addr_l);
      end
      hv_l = hold_valid_o; host_l = host_mode_i; wr_l = host_wr_i;
      hd_l = host_data_i; addr_l = addr_o;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(fifo_ren_no == 1'b1, "R1", fifo_ren_no, 1);
    chk(hold_valid_o == 1'b0, "R1", hold_valid_o, 0);
    chk(addr_o == '0, "R1", addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(addr_o == '0 && hold_valid_o == 1'b0, "R1", addr_o, 0);
    mon_on = 1'b1;

    // R3: pops with data present, upper bits set (R6 truncation)
    fq.push_back(23'h7A_BCDE); fq.push_back(23'h41_2345); fq.push_back(23'h00_0001);
    tick(0, 0, 0, '0);
    tick(1, 0, 0, '0);
    chk(prev_rd == 1'b1, "R3", prev_rd, 1);
    tick(1, 0, 0, '0);
    chk(prev_rd == 1'b1, "R3", prev_rd, 1);
    tick(0, 0, 0, '0);
    chk(prev_rd == 1'b0, "R3", prev_rd, 0);
    tick(1, 0, 0, '0);
    repeat (4) tick(0, 0, 0, '0);
    chk(rd_total == 3, "R3", rd_total, 3);

    // R4: pops while empty stay pending
    base = rd_total;
    tick(1, 0, 0, '0);
    tick(1, 0, 0, '0);
    repeat (3) tick(0, 0, 0, '0);
    chk(rd_total == base, "R4", rd_total, base);
    fq.push_back(23'h15_5555); fq.push_back(23'h6A_AAAA);
    tick(0, 0, 0, '0);
    chk(prev_rd == 1'b1, "R4", prev_rd, 1);
    repeat (5) tick(0, 0, 0, '0);
    chk(rd_total == base + 2, "R4", rd_total, base + 2);

    // R8/R9: host mode suspends reads, host writes load address
    base = rd_total;
    fq.push_back(23'h12_3456);
    tick(0, 1, 0, '0);
    tick(1, 1, 1, 17'h1_F00D);
    tick(0, 1, 0, '0);
    tick(0, 1, 1, 17'h0_0BEE);
    repeat (2) tick(0, 1, 0, '0);
    chk(rd_total == base, "R8", rd_total, base);
    tick(0, 0, 0, '0);
    chk(prev_rd == 1'b1, "R8", prev_rd, 1);
    repeat (4) tick(0, 0, 0, '0);

    // R10: hit landing while host mode is on is dropped
    fq.push_back(23'h3C_3C3C);
    tick(1, 0, 0, '0);
    tick(0, 1, 0, '0);
    tick(0, 1, 0, '0);
    tick(0, 0, 0, '0);
    repeat (4) tick(0, 0, 0, '0);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule